// File: doc/BRIEF.md
# Windowed Heartbeat Watchdog

This block watches a software heartbeat and flags a fault when two consecutive falling edges of that heartbeat are either too close together or too far apart. The upper bound of the valid window is a fixed cycle count, `SLOW_LIMIT`. The lower bound is derived from it by dividing by a ratio of 8, 16 or 64. Two strap inputs select the ratio, and one strap code switches the watchdog off.

The block does not make the system reset pulse itself. It emits a one-cycle `fault_pulse` that a separate reset generator turns into a reset of the full timeout length. That generator reports back through `sys_rst_active`. While this input is high, the watchdog ignores the heartbeat. It starts timing again from the moment reset is released. A two-bit status shows which kinds of fault have occurred since the last release.

Timing convention: a *clearing edge* is a rising clock edge at which any of the following happens:
- a valid heartbeat edge is taken;
- a fault is emitted;
- `sys_rst_active` is sampled high;
- the strap code differs from the code sampled at the previous edge;
- the off code is sampled.

The index n counts the rising clock edges after the most recent clearing edge, starting at 1. A heartbeat falling edge is *taken* at the clock edge that samples `hb_in` low when the previous edge sampled it high. Outputs change at the clock edge that makes the decision.

Top module: `wwd_top`

## Requirements
- R1: The strap code {sel_a, sel_b} selects the fast limit FAST = SLOW_LIMIT / ratio. Code 00 gives ratio 8, code 01 gives ratio 16 and code 11 gives ratio 64. With SLOW_LIMIT = 512 these are 64, 32 and 8 cycles.
- R2: If no valid heartbeat edge is taken, `fault_pulse` rises at clock edge n = SLOW_LIMIT and `fault_kind` bit 1 (late) is set.
- R3: A heartbeat edge taken at n < FAST raises `fault_pulse` at that edge and sets `fault_kind` bit 0 (early).
- R4: A heartbeat edge taken at FAST <= n < SLOW_LIMIT causes no fault and starts a new interval. The case n = FAST is included.
- R5: Code 10 disables the watchdog. No fault occurs for any heartbeat pattern or any length of silence, and the timer is held cleared.
- R6: While `sys_rst_active` is high, no fault occurs and heartbeat edges are ignored. The first interval after release counts n = 1 at the first clock edge that samples `sys_rst_active` low.
- R7: Any change of the strap code clears the timer, so the next interval is measured from the edge that sampled the new code.
- R8: `fault_pulse` is high for exactly one cycle per fault, and the timer restarts from the faulting edge.
- R9: The `fault_kind` bits are sticky. They accumulate across faults and are cleared at the first clock edge that samples `sys_rst_active` low after it was high.
- R10: Synchronous reset `rst` drives `fault_pulse` and `fault_kind` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_in | input | 1 | Heartbeat; falling edges are the service events |
| sys_rst_active | input | 1 | High while the system reset pulse is being driven |
| sel_a | input | 1 | Strap, first bit of the ratio code |
| sel_b | input | 1 | Strap, second bit of the ratio code |
| fault_pulse | output | 1 | One-cycle strobe on each window violation |
| fault_kind | output | 2 | Sticky fault type: bit 0 early, bit 1 late |

## Verification
Two situations are hardest to reach from the ports. The first is a strap change that lands just before the late limit would expire. The second is a heartbeat edge placed exactly on a window boundary. The stimulus tracks clearing edges and drops `hb_in` at a counted clock offset from them, so edges land exactly at n = FAST and at n = FAST - 1. For the strap case, the timer is left to run to within a few cycles of expiry before the code is changed. The bench then confirms that the late fault arrives a full `SLOW_LIMIT` edges after the change instead of a few cycles later. A behavioural model in the bench is compared with both outputs on every clock.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    // Strap code {sel_a, sel_b}
    typedef enum logic [1:0] {
        WIN_R8  = 2'b00,
        WIN_R16 = 2'b01,
        WIN_OFF = 2'b10,
        WIN_R64 = 2'b11
    } win_mode_e;

    // Outcome of one timer evaluation
    typedef enum logic [1:0] {
        VERD_NONE,
        VERD_OK,
        VERD_EARLY,
        VERD_LATE
    } verdict_e;

    // Sticky status, bit 1 late, bit 0 early
    typedef struct packed {
        logic late;
        logic early;
    } fault_kind_t;

    localparam int unsigned MODE_COUNT = 4;

    // log2 of the window ratio; the off code maps to 0 (unused)
    function automatic int unsigned ratio_shift(input win_mode_e m);
        case (m)
            WIN_R8:  return 3;
            WIN_R16: return 4;
            WIN_R64: return 6;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/wwd_strap_decode.sv
module wwd_strap_decode
    import wwd_pkg::*;
#(
    parameter int unsigned SLOW_LIMIT = 512,
    parameter int unsigned CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_a,
    input  logic             sel_b,
    output logic             win_enable,
    output logic             strap_moved,
    output logic [CNT_W-1:0] fast_limit
);

    win_mode_e        mode_now;
    win_mode_e        mode_q;
    logic [CNT_W-1:0] fast_tab [MODE_COUNT];

    assign mode_now = win_mode_e'({sel_a, sel_b});

    // One fast limit per strap code, computed from the slow limit
    for (genvar g = 0; g < MODE_COUNT; g++) begin : g_fast
        assign fast_tab[g] = CNT_W'(SLOW_LIMIT >> ratio_shift(win_mode_e'(2'(g))));
    end

    // Reset loads the present code so no change is seen on the first edge
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_now;
        end else begin
            mode_q <= mode_now;
        end
    end

    assign fast_limit  = fast_tab[{sel_a, sel_b}];
    assign win_enable  = (mode_now != WIN_OFF);
    assign strap_moved = (mode_now != mode_q);

endmodule

// File: rtl/wwd_beat_edge.sv
module wwd_beat_edge (
    input  logic clk,
    input  logic rst,
    input  logic hb_in,
    input  logic sys_rst_active,
    output logic beat_fall,
    output logic rst_released
);

    logic hb_q;
    logic act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_q  <= 1'b0;
            act_q <= 1'b1;
        end else begin
            hb_q  <= hb_in;
            act_q <= sys_rst_active;
        end
    end

    assign beat_fall    = hb_q & ~hb_in;
    assign rst_released = act_q & ~sys_rst_active;

endmodule

// File: rtl/wwd_window_timer.sv
module wwd_window_timer
    import wwd_pkg::*;
#(
    parameter int unsigned SLOW_LIMIT = 512,
    parameter int unsigned CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             beat_fall,
    input  logic             rst_released,
    input  logic [CNT_W-1:0] fast_limit,
    output logic             fault_pulse,
    output fault_kind_t      fault_kind
);

    localparam logic [CNT_W-1:0] SLOW_C  = CNT_W'(SLOW_LIMIT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    verdict_e         verdict;
    fault_kind_t      kind_next;

    // cnt holds n, the index of the edge being evaluated
    always_comb begin
        verdict  = VERD_NONE;
        cnt_next = cnt + 1'b1;
        if (hold) begin
            cnt_next = CNT_ONE;
        end else if (cnt == SLOW_C) begin
            verdict  = VERD_LATE;
            cnt_next = CNT_ONE;
        end else if (beat_fall) begin
            verdict  = (cnt < fast_limit) ? VERD_EARLY : VERD_OK;
            cnt_next = CNT_ONE;
        end
    end

    always_comb begin
        kind_next = rst_released ? '0 : fault_kind;
        if (verdict == VERD_EARLY) kind_next.early = 1'b1;
        if (verdict == VERD_LATE)  kind_next.late  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= CNT_ONE;
            fault_pulse <= 1'b0;
            fault_kind  <= '0;
        end else begin
            cnt         <= cnt_next;
            fault_pulse <= (verdict == VERD_EARLY) || (verdict == VERD_LATE);
            fault_kind  <= kind_next;
        end
    end

endmodule

// File: rtl/wwd_top.sv
module wwd_top
    import wwd_pkg::*;
#(
    parameter int unsigned SLOW_LIMIT = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hb_in,
    input  logic       sys_rst_active,
    input  logic       sel_a,
    input  logic       sel_b,
    output logic       fault_pulse,
    output logic [1:0] fault_kind
);

    localparam int unsigned CNT_W = $clog2(SLOW_LIMIT + 1);

    logic             win_enable;
    logic             strap_moved;
    logic [CNT_W-1:0] fast_limit;
    logic             beat_fall;
    logic             rst_released;
    logic             hold;
    fault_kind_t      kind_s;

    wwd_strap_decode #(
        .SLOW_LIMIT (SLOW_LIMIT),
        .CNT_W      (CNT_W)
    ) u_decode (
        .clk         (clk),
        .rst         (rst),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .win_enable  (win_enable),
        .strap_moved (strap_moved),
        .fast_limit  (fast_limit)
    );

    wwd_beat_edge u_edge (
        .clk            (clk),
        .rst            (rst),
        .hb_in          (hb_in),
        .sys_rst_active (sys_rst_active),
        .beat_fall      (beat_fall),
        .rst_released   (rst_released)
    );

    assign hold = sys_rst_active | strap_moved | ~win_enable;

    wwd_window_timer #(
        .SLOW_LIMIT (SLOW_LIMIT),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .hold         (hold),
        .beat_fall    (beat_fall),
        .rst_released (rst_released),
        .fast_limit   (fast_limit),
        .fault_pulse  (fault_pulse),
        .fault_kind   (kind_s)
    );

    assign fault_kind = kind_s;

endmodule

// File: rtl/wwd_top_chk.sv
module wwd_top_chk (
    input logic       clk,
    input logic       rst,
    input logic       sys_rst_active,
    input logic       sel_a,
    input logic       sel_b,
    input logic       fault_pulse,
    input logic [1:0] fault_kind
);

    assert_quiet_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
        sys_rst_active |=> !fault_pulse);

    assert_off_code_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_a && !sel_b) |=> !fault_pulse);

    assert_strap_change_R7: assert property (@(posedge clk) disable iff (rst)
        ({sel_a, sel_b} != $past({sel_a, sel_b})) |=> !fault_pulse);

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> !fault_pulse);

    assert_kind_on_fault_R9: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (fault_kind != 2'b00));

    assert_release_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_active) |=> ((fault_kind == 2'b00) || fault_pulse));

    assert_sticky_bits_R9: assert property (@(posedge clk) disable iff (rst)
        !$fell(sys_rst_active) |=> ((fault_kind & $past(fault_kind)) == $past(fault_kind)));

endmodule

bind wwd_top wwd_top_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sys_rst_active (sys_rst_active),
    .sel_a          (sel_a),
    .sel_b          (sel_b),
    .fault_pulse    (fault_pulse),
    .fault_kind     (fault_kind)
);

// File: tb/wwd_top_test.sv
`timescale 1ns/1ps
module wwd_top_test;

    localparam int SLOW = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hb = 1'b1;
    logic       act = 1'b1;
    logic       sa = 1'b0;
    logic       sb = 1'b0;
    logic       fault;
    logic [1:0] kind;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R10";
    bit    done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    wwd_top #(.SLOW_LIMIT(SLOW)) uut (
        .clk            (clk),
        .rst            (rst),
        .hb_in          (hb),
        .sys_rst_active (act),
        .sel_a          (sa),
        .sel_b          (sb),
        .fault_pulse    (fault),
        .fault_kind     (kind)
    );

    task automatic check(input string req, input int act_v, input int exp_v, input string what);
        n_checks++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    function automatic int ratio_of(input logic [1:0] c);
        case (c)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b11:   return 64;
            default: return 1;
        endcase
    endfunction

    // Behavioural reference: n counts edges since the last clearing edge
    int         m_n    = 1;
    bit         m_hbq  = 1'b0;
    logic [1:0] m_code = 2'b00;
    bit         m_act  = 1'b1;
    bit         m_fault = 1'b0;
    logic [1:0] m_kind = 2'b00;

    always @(posedge clk) begin
        bit         fall;
        bit         moved;
        bit         f;
        logic [1:0] code;
        logic [1:0] newk;
        int         fastv;
        code = {sa, sb};
        if (rst) begin
            m_n = 1; m_hbq = 1'b0; m_code = code; m_act = 1'b1;
            m_fault = 1'b0; m_kind = 2'b00;
        end else begin
            fall  = m_hbq && !hb;
            moved = (code != m_code);
            fastv = SLOW / ratio_of(code);
            f = 1'b0; newk = 2'b00;
            if (m_act && !act) m_kind = 2'b00;
            if (act || moved || code == 2'b10) begin
                m_n = 1;
            end else if (m_n == SLOW) begin
                f = 1'b1; newk = 2'b10; m_n = 1;
            end else if (fall) begin
                if (m_n < fastv) begin f = 1'b1; newk = 2'b01; end
                m_n = 1;
            end else begin
                m_n = m_n + 1;
            end
            m_fault = f;
            m_kind  = m_kind | newk;
            m_hbq   = hb;
            m_code  = code;
            m_act   = act;
        end
        #2;
        if (!done) begin
            check(cur_req, int'(fault), int'(m_fault), "fault_pulse vs model");
            check(cur_req, int'(kind), int'(m_kind), "fault_kind vs model");
        end
    end

    // Called just after a clearing edge; the fall is taken at edge n
    task automatic beat(input int n);
        repeat (n - 1) @(negedge clk);
        hb = 1'b0;
        @(negedge clk);
        hb = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10", int'(fault), 0, "fault_pulse in reset");
        check("R10", int'(kind), 0, "fault_kind in reset");
        rst = 1'b0;
        @(negedge clk);

        // Release system reset; next edge is n = 1
        cur_req = "R4";
        act = 1'b0;
        beat(64);
        check("R4", int'(fault), 0, "edge at n = FAST (ratio 8) is valid");
        cur_req = "R3";
        beat(63);
        check("R3", int'(fault), 1, "edge at n = FAST-1 is early");
        check("R3", int'(kind), 1, "early bit set");
        cur_req = "R9";
        beat(100);
        check("R4", int'(fault), 0, "mid-window edge valid");
        check("R9", int'(kind), 1, "early bit held");

        // R2: late fault at n = SLOW
        cur_req = "R2";
        for (int k = 1; k < SLOW; k++) begin
            @(negedge clk);
            check("R2", int'(fault), 0, "no fault before slow limit");
        end
        @(negedge clk);
        check("R2", int'(fault), 1, "late fault at n = SLOW");
        check("R9", int'(kind), 3, "late bit added to early bit");
        @(negedge clk);
        check("R8", int'(fault), 0, "strobe lasts one cycle");

        // R6: heartbeat ignored while system reset is active
        cur_req = "R6";
        act = 1'b1;
        for (int k = 0; k < 4; k++) begin
            beat(3);
            check("R6", int'(fault), 0, "no fault while reset active");
        end
        check("R9", int'(kind), 3, "status held during reset");
        act = 1'b0;
        beat(63);
        check("R6", int'(fault), 1, "first interval counted from release");
        check("R9", int'(kind), 1, "release cleared old bits");
        cur_req = "R4";
        beat(64);
        check("R4", int'(fault), 0, "boundary edge after release");

        // R1: ratio 16
        cur_req = "R1";
        sb = 1'b1;
        @(negedge clk);
        beat(31);
        check("R1", int'(fault), 1, "ratio 16 early at n = 31");
        beat(32);
        check("R1", int'(fault), 0, "ratio 16 valid at n = 32");

        // R1: ratio 64
        sa = 1'b1;
        @(negedge clk);
        beat(7);
        check("R1", int'(fault), 1, "ratio 64 early at n = 7");
        beat(8);
        check("R1", int'(fault), 0, "ratio 64 valid at n = 8");

        // R7: strap change shortly before expiry restarts the timer
        cur_req = "R7";
        repeat (500) @(negedge clk);
        sa = 1'b0;
        @(negedge clk);
        for (int k = 1; k < SLOW; k++) begin
            @(negedge clk);
            check("R7", int'(fault), 0, "no fault before restarted limit");
        end
        @(negedge clk);
        check("R7", int'(fault), 1, "late fault a full window after change");
        check("R7", int'(kind), 3, "late bit set after change");

        // R5: off code
        cur_req = "R5";
        sa = 1'b1;
        sb = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            beat(2);
            check("R5", int'(fault), 0, "rapid beats ignored when off");
        end
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            check("R5", int'(fault), 0, "silence ignored when off");
        end
        check("R5", int'(kind), 3, "status untouched when off");

        // Back to ratio 8
        cur_req = "R1";
        sa = 1'b0;
        @(negedge clk);
        beat(64);
        check("R1", int'(fault), 0, "ratio 8 valid after re-enable");
        beat(10);
        check("R1", int'(fault), 1, "ratio 8 early after re-enable");
        @(negedge clk);
        check("R8", int'(fault), 0, "strobe cleared next cycle");

        finish_run();
    end

endmodule